// File: doc/BRIEF.md
# Byte FIFO pair with threshold and error interrupts for a two-wire bus controller

This block sits between a simple register bus and a two-wire serial protocol engine. It holds one byte queue per direction. Software fills the transmit queue through a data address, and the engine drains it. The engine fills the receive queue, and software drains it through the same data address. Each queue reports its fill level and its full and empty state through a status word. Each queue also has a programmable threshold that raises a low-water flag (transmit) or a high-water flag (receive).

Errors in both directions are caught: writes into a full queue, pops from an empty queue, pushes into a full queue and reads from an empty queue. An idle timer flags receive data that has been left sitting in the queue while no new byte arrives. Five single-cycle event strobes from the engine (done, abort, missing acknowledge, no device, timeout) are latched into the same status word. The status word is write-one-to-clear. A single registered interrupt line is the OR of every status bit that its enable bit lets through.

Register map (word address on `bus_addr`): 0 queue configuration, 1 interrupt enable, 2 interrupt status, 3 queue status, 4 data (a write pushes a transmit byte, a read pops a receive byte), 5 idle-timer limit. Addresses 6 and 7 read as zero. Read data is registered and is valid in the cycle after the read strobe. `DEPTH` may be at most 64, so that a level fits its 7-bit field.

Top module: `i2c_fifo_irq`

## Requirements
- R1: Bytes written to address 4 leave the transmit queue in write order. The oldest byte is shown on `eng_tx_data`, and `eng_tx_pop` removes it. Bytes pushed by the engine are returned in arrival order by reads of address 4. Each queue holds `DEPTH` bytes.
- R2: A read of address 3 returns the transmit level in bits [6:0], transmit full in bit 7, transmit empty in bit 8, the receive level in bits [22:16], receive full in bit 23 and receive empty in bit 24. All other bits read zero, and addresses 6 and 7 read zero.
- R3: Address 0 holds the receive enable in bit 0, the transmit enable in bit 1, the receive threshold starting at bit 4 and the transmit threshold starting at bit 16 (each `$clog2(DEPTH+1)` bits wide). While an enable is clear, its queue is emptied from the next cycle on, its pushes and pops are ignored, and it sets no status bit.
- R4: Status bit 0 (transmit low-water) is set on every cycle in which transmit is enabled and the transmit level is at or below the transmit threshold.
- R5: Status bit 1 (receive high-water) is set on every cycle in which receive is enabled and the receive level is at or above the receive threshold.
- R6: A write to address 4 while the transmit queue is full drops the byte and sets status bit 3. An `eng_tx_pop` while the transmit queue is empty sets status bit 2.
- R7: An `eng_rx_push` while the receive queue is full drops the byte and sets status bit 5. A read of address 4 while the receive queue is empty returns zero and sets status bit 4.
- R8: Address 5 bits [3:0] set an idle limit. The idle count clears on every engine push and whenever the receive queue is empty or disabled, and it otherwise counts up to the limit. Status bit 6 is set on each cycle in which the receive queue holds data, no push occurs and the count has reached the limit.
- R9: `eng_evt` bits 0 to 4 set status bits 7 to 11 respectively (done, abort, no acknowledge, no device, timeout).
- R10: A write to address 2 clears each status bit written as one. A bit whose cause occurs in the same cycle stays set. Status bits change at the clock edge after their cause.
- R11: Address 1 bits [11:0] enable the status bits. `irq` is high exactly while some status bit and its enable bit are both one, and it updates at the same edge as the status.
- R12: After reset, all registers read zero, both queues are empty, and `irq` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| eng_tx_pop | input | 1 | Engine removes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_evt | input | 5 | Transfer event strobes: done, abort, no acknowledge, no device, timeout |
| irq | output | 1 | Registered interrupt request |

## Verification
The queues are driven first with short directed sequences: a partial fill that crosses the transmit threshold in both directions, a fill to exactly `DEPTH` plus one byte, a drain past empty, and a receive fill that stops below the threshold so that the idle timer can be observed. These sequences separate the threshold comparisons (at or below versus at or above) from the overflow and underflow detection, and they show that a dropped byte never reappears. A stretch of random traffic then interleaves pushes, pops, status clears, enable changes and event strobes. This tests simultaneous set and clear, simultaneous push and pop at the empty and full boundaries, and the timer restarting on arrival, all against a queue-based reference model.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int ADDR_W  = 3;
  localparam int NSTAT   = 12;
  localparam int TRAIL_W = 4;
  localparam int NEVT    = 5;

  localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ISTAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_FSTAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_TRAIL = 3'd5;

  localparam int ST_TX_LOW  = 0;
  localparam int ST_RX_HIGH = 1;
  localparam int ST_TX_UND  = 2;
  localparam int ST_TX_OVR  = 3;
  localparam int ST_RX_UND  = 4;
  localparam int ST_RX_OVR  = 5;
  localparam int ST_IDLE    = 6;
  localparam int ST_EVT0    = 7;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6 R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/i2cf_idle_timer.sv
module i2cf_idle_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          arrive,
  input  logic [TW-1:0] limit,
  output logic          hit
);
  logic [TW-1:0] cnt;

  assign hit = active && !arrive && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !active || arrive) cnt <= '0;
    else if (cnt < limit)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cf_irq_status.sv
module i2cf_irq_status #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] stat,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] stat_n, en_n;

  assign stat_n = (stat & ~clr) | set;
  assign en_n   = en_wr ? en_wdata : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_n;
      en   <= en_n;
      irq  <= |(stat_n & en_n);
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((stat & $past(set)) == $past(set)));

  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~set) != '0) |=> ((stat & $past(clr & ~set)) == '0));

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(stat & en)));
endmodule

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq
  import i2cf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              eng_tx_pop,
  output logic [7:0]        eng_tx_data,
  input  logic              eng_rx_push,
  input  logic [7:0]        eng_rx_data,
  input  logic [NEVT-1:0]   eng_evt,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic               tx_en, rx_en;
  logic [CW-1:0]      tx_trig, rx_trig;
  logic [TRAIL_W-1:0] idle_lim;
  logic [CW-1:0]      tx_cnt, rx_cnt;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]         rx_head;
  logic [NSTAT-1:0]   set_v, clr_v, stat, ien;
  logic               idle_hit;
  logic               wr_data, rd_data;
  logic [31:0]        fstat_w, cfg_w;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_data = bus_wr && (bus_addr == ADR_DATA);
  assign rd_data = bus_rd && (bus_addr == ADR_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
      tx_trig  <= '0;
      rx_trig  <= '0;
      idle_lim <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADR_CFG) begin
        rx_en   <= bus_wdata[0];
        tx_en   <= bus_wdata[1];
        rx_trig <= bus_wdata[4 +: CW];
        tx_trig <= bus_wdata[16 +: CW];
      end
      if (bus_addr == ADR_TRAIL) idle_lim <= bus_wdata[TRAIL_W-1:0];
    end
  end

  i2cf_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst(rst), .flush(!tx_en),
    .push(wr_data && tx_en), .pop(eng_tx_pop && tx_en), .wdata(bus_wdata[7:0]),
    .head(eng_tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  i2cf_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst(rst), .flush(!rx_en),
    .push(eng_rx_push && rx_en), .pop(rd_data && rx_en), .wdata(eng_rx_data),
    .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  i2cf_idle_timer #(.TW(TRAIL_W)) u_idle (
    .clk(clk), .rst(rst), .active(rx_en && !rx_empty), .arrive(eng_rx_push),
    .limit(idle_lim), .hit(idle_hit));

  always_comb begin
    set_v             = '0;
    set_v[ST_TX_LOW]  = tx_en && (tx_cnt <= tx_trig);
    set_v[ST_RX_HIGH] = rx_en && (rx_cnt >= rx_trig);
    set_v[ST_TX_UND]  = tx_en && eng_tx_pop && tx_empty;
    set_v[ST_TX_OVR]  = tx_en && wr_data && tx_full;
    set_v[ST_RX_UND]  = rx_en && rd_data && rx_empty;
    set_v[ST_RX_OVR]  = rx_en && eng_rx_push && rx_full;
    set_v[ST_IDLE]    = idle_hit;
    set_v[ST_EVT0 +: NEVT] = eng_evt;
  end

  assign clr_v = (bus_wr && bus_addr == ADR_ISTAT) ? bus_wdata[NSTAT-1:0] : '0;

  i2cf_irq_status #(.N(NSTAT)) u_irq (
    .clk(clk), .rst(rst), .set(set_v), .clr(clr_v),
    .en_wr(bus_wr && bus_addr == ADR_IEN), .en_wdata(bus_wdata[NSTAT-1:0]),
    .stat(stat), .en(ien), .irq(irq));

  assign fstat_w = {7'b0, rx_empty, rx_full, 7'(rx_cnt), 7'b0, tx_empty, tx_full, 7'(tx_cnt)};
  assign cfg_w   = (32'(tx_trig) << 16) | (32'(rx_trig) << 4) | {30'b0, tx_en, rx_en};

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        ADR_CFG:   bus_rdata <= cfg_w;
        ADR_IEN:   bus_rdata <= 32'(ien);
        ADR_ISTAT: bus_rdata <= 32'(stat);
        ADR_FSTAT: bus_rdata <= fstat_w;
        ADR_DATA:  bus_rdata <= (rx_en && !rx_empty) ? 32'(rx_head) : '0;
        ADR_TRAIL: bus_rdata <= 32'(idle_lim);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R7
  rx_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_en && rx_empty) |=> (bus_rdata == '0 && stat[ST_RX_UND]));

  // R6
  tx_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_en && tx_full) |=> stat[ST_TX_OVR]);
endmodule

// File: tb/i2c_fifo_irq_test.sv
module i2c_fifo_irq_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH+1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0]  eng_tx_data, eng_rx_data = '0;
  logic [4:0]  eng_evt = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  i2c_fifo_irq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .eng_evt(eng_evt), .irq(irq));

  // reference model state
  logic [7:0]  m_txq[$], m_rxq[$];
  bit          m_txen, m_rxen, m_irq;
  int          m_txtrig, m_rxtrig, m_tlim, m_tcnt;
  logic [11:0] m_stat, m_ien;
  logic [31:0] m_rdata;
  logic [2:0]  m_last;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R3 config readback";
      3'd1: return "R11 enable readback";
      3'd2: return "R10 status readback";
      3'd4: return "R1 receive data";
      3'd5: return "R8 limit readback";
      default: return "R2 queue status";
    endcase
  endfunction

  always @(posedge clk) begin
    int txn, rxn;
    logic [11:0] s, c;
    started = 1;
    if (rst) begin
      m_txq.delete(); m_rxq.delete();
      m_txen = 0; m_rxen = 0; m_irq = 0;
      m_txtrig = 0; m_rxtrig = 0; m_tlim = 0; m_tcnt = 0;
      m_stat = '0; m_ien = '0; m_rdata = '0; m_last = 3'd3;
    end else begin
      txn = m_txq.size(); rxn = m_rxq.size(); s = '0;
      if (m_txen && txn <= m_txtrig) s[0] = 1'b1;
      if (m_rxen && rxn >= m_rxtrig) s[1] = 1'b1;
      if (m_rxen && rxn != 0 && !eng_rx_push && m_tcnt >= m_tlim) s[6] = 1'b1;
      if (bus_rd) begin
        m_last = bus_addr;
        case (bus_addr)
          3'd0: m_rdata = (32'(m_txtrig) << 16) | (32'(m_rxtrig) << 4) | (32'(m_txen) << 1) | 32'(m_rxen);
          3'd1: m_rdata = 32'(m_ien);
          3'd2: m_rdata = 32'(m_stat);
          3'd3: m_rdata = (32'(rxn == 0) << 24) | (32'(rxn == DEPTH) << 23) | (32'(rxn) << 16)
                        | (32'(txn == 0) << 8) | (32'(txn == DEPTH) << 7) | 32'(txn);
          3'd4: m_rdata = (m_rxen && rxn > 0) ? 32'(m_rxq[0]) : 32'd0;
          3'd5: m_rdata = 32'(m_tlim);
          default: m_rdata = '0;
        endcase
      end
      if (m_txen) begin
        if (bus_wr && bus_addr == 3'd4) begin
          if (txn < DEPTH) m_txq.push_back(bus_wdata[7:0]); else s[3] = 1'b1;
        end
        if (eng_tx_pop) begin
          if (txn > 0) void'(m_txq.pop_front()); else s[2] = 1'b1;
        end
      end else m_txq.delete();
      if (m_rxen) begin
        if (bus_rd && bus_addr == 3'd4) begin
          if (rxn > 0) void'(m_rxq.pop_front()); else s[4] = 1'b1;
        end
        if (eng_rx_push) begin
          if (rxn < DEPTH) m_rxq.push_back(eng_rx_data); else s[5] = 1'b1;
        end
      end else m_rxq.delete();
      if (!m_rxen || rxn == 0 || eng_rx_push) m_tcnt = 0;
      else if (m_tcnt < m_tlim) m_tcnt++;
      s[11:7] = eng_evt;
      c = (bus_wr && bus_addr == 3'd2) ? bus_wdata[11:0] : '0;
      m_stat = (m_stat & ~c) | s;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin
            m_rxen = bus_wdata[0]; m_txen = bus_wdata[1];
            m_rxtrig = int'(bus_wdata[4 +: CW]); m_txtrig = int'(bus_wdata[16 +: CW]);
          end
          3'd1: m_ien = bus_wdata[11:0];
          3'd5: m_tlim = int'(bus_wdata[3:0]);
          default: ;
        endcase
      end
      m_irq = |(m_stat & m_ien);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(irq == m_irq, "R11 irq line", 32'(irq), 32'(m_irq));
      check(bus_rdata == m_rdata, tag_of(m_last), bus_rdata, m_rdata);
      if (m_txq.size() > 0)
        check(eng_tx_data == m_txq[0], "R1 transmit head", 32'(eng_tx_data), 32'(m_txq[0]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic epop();
    @(negedge clk); eng_tx_pop = 1;
    @(negedge clk); eng_tx_pop = 0;
  endtask

  task automatic epush(input logic [7:0] b);
    @(negedge clk); eng_rx_push = 1; eng_rx_data = b;
    @(negedge clk); eng_rx_push = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 0;
    // R12 reset state
    rd(3'd1, d); check(d == 0, "R12 enable after reset", d, 0);
    rd(3'd2, d); check(d == 0, "R12 status after reset", d, 0);
    rd(3'd0, d); check(d == 0, "R12 config after reset", d, 0);
    rd(3'd3, d); check(d == 32'h0100_0100, "R12 queues empty after reset", d, 32'h0100_0100);
    check(irq == 0, "R12 irq after reset", 32'(irq), 0);

    // R4 low-water threshold
    wr(3'd0, 32'h0002_0043);
    wr(3'd4, 32'hA1); wr(3'd4, 32'hA2); wr(3'd4, 32'hA3);
    wr(3'd2, 32'h1);
    rd(3'd2, d); check(d[0] == 0, "R4 level 3 above threshold 2", 32'(d[0]), 0);
    epop();
    rd(3'd2, d); check(d[0] == 1, "R4 level 2 at threshold", 32'(d[0]), 1);

    // R6 transmit overrun and underrun
    for (int i = 0; i < 14; i++) wr(3'd4, 32'(8'hB0 + i));
    rd(3'd3, d); check(d == 32'h0100_0090, "R2 transmit full layout", d, 32'h0100_0090);
    wr(3'd4, 32'hEE);
    rd(3'd2, d); check(d[3] == 1, "R6 write into full transmit", 32'(d[3]), 1);
    for (int i = 0; i < 17; i++) epop();
    rd(3'd2, d); check(d[2] == 1, "R6 pop from empty transmit", 32'(d[2]), 1);

    // R5 R8 receive thresholds and idle timer
    wr(3'd2, 32'hFFF);
    wr(3'd5, 32'hF);
    epush(8'h51); epush(8'h52); epush(8'h53);
    rd(3'd2, d);
    check(d[1] == 0, "R5 level 3 below threshold 4", 32'(d[1]), 0);
    check(d[6] == 0, "R8 idle limit not reached", 32'(d[6]), 0);
    epush(8'h54);
    rd(3'd2, d); check(d[1] == 1, "R5 level 4 at threshold", 32'(d[1]), 1);
    wr(3'd5, 32'h2);
    repeat (10) @(negedge clk);
    rd(3'd2, d); check(d[6] == 1, "R8 idle limit reached", 32'(d[6]), 1);

    // R7 receive overrun and underrun
    for (int i = 0; i < 13; i++) epush(8'h60 + 8'(i));
    rd(3'd2, d); check(d[5] == 1, "R7 push into full receive", 32'(d[5]), 1);
    for (int i = 0; i < 16; i++) rd(3'd4, d);
    rd(3'd4, d); check(d == 0, "R7 read of empty receive", d, 0);
    rd(3'd2, d); check(d[4] == 1, "R7 underrun flag", 32'(d[4]), 1);

    // R9 engine events
    wr(3'd2, 32'hFFF);
    @(negedge clk); eng_evt = 5'b10101;
    @(negedge clk); eng_evt = 5'b00000;
    rd(3'd2, d); check((d & 32'hF80) == 32'hA80, "R9 event bits", d & 32'hF80, 32'hA80);

    // R10 set wins over clear
    @(negedge clk); bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'h080; eng_evt = 5'b00001;
    @(negedge clk); bus_wr = 0; eng_evt = 5'b00000;
    rd(3'd2, d); check(d[7] == 1, "R10 set in clear cycle survives", 32'(d[7]), 1);
    wr(3'd2, 32'h080);
    rd(3'd2, d); check(d[7] == 0, "R10 write one clears", 32'(d[7]), 0);

    // R11 masked interrupt
    wr(3'd1, 32'h200);
    check(irq == 1, "R11 enabled status raises irq", 32'(irq), 1);
    wr(3'd2, 32'h200);
    check(irq == 0, "R11 irq drops after clear", 32'(irq), 0);

    // R3 disabled queues
    wr(3'd4, 32'h11); wr(3'd4, 32'h12);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h77);
    epop();
    wr(3'd2, 32'hFFF);
    rd(3'd3, d); check(d == 32'h0100_0100, "R3 disabled queues emptied", d, 32'h0100_0100);
    rd(3'd2, d); check(d == 0, "R3 disabled queues raise nothing", d, 0);

    // random traffic against the model
    wr(3'd0, 32'h0003_0053);
    wr(3'd1, 32'hFFF);
    for (int i = 0; i < 3000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom_range(0, 99);
      bus_wr = 0; bus_rd = 0; bus_wdata = $urandom;
      if (r < 30)      begin bus_wr = 1; bus_addr = 3'd4; end
      else if (r < 45) begin bus_rd = 1; bus_addr = 3'd4; end
      else if (r < 52) begin bus_rd = 1; bus_addr = 3'($urandom_range(0, 7)); end
      else if (r < 56) begin bus_wr = 1; bus_addr = 3'd2; end
      else if (r < 58) begin bus_wr = 1; bus_addr = 3'd1; end
      else if (r < 59) begin
        bus_wr = 1; bus_addr = 3'd0;
        if ($urandom_range(0, 7) != 0) bus_wdata = bus_wdata | 32'h3;
      end
      else if (r < 60) begin bus_wr = 1; bus_addr = 3'd5; end
      eng_tx_pop  = ($urandom_range(0, 3) == 0);
      eng_rx_push = ($urandom_range(0, 3) == 0);
      eng_rx_data = 8'($urandom);
      eng_evt     = ($urandom_range(0, 19) == 0) ? 5'($urandom) : 5'b0;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; eng_evt = 0;
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule